// File: doc/BRIEF.md
# Descriptor Ring Walking Sequencer

This block walks a ring of transfer descriptors kept in word-wide memory. Starting from a programmable ring base, it reads the first control word of each descriptor and tests its valid flag. A valid descriptor is handed to a processing engine through a one-cycle start pulse, together with the descriptor address and a destination-read hint. When the engine signals done, the sequencer writes the control word back to the same address with the valid flag cleared. It then fetches the next slot, jumps back to the ring base, or halts.

A run ends in one of three ways: an invalid descriptor is fetched, a descriptor carries the explicit last flag, or the host clears the enable bit. In each case the enable bit reads 0 afterwards, and a two-bit cause code tells the host which event ended the run. Every memory access completes before the next one is issued, so fetches and write-backs stay strictly ordered.

Control word flag bits: bit 0 valid, bit 1 wrap-to-base, bit 2 last, bit 3 destination-read. Each descriptor takes `DESC_WORDS` words of `DATA_W` bits.

Top module: `desc_ring_seq`

## Requirements
- R1: A fetched control word with bit 0 = 0 starts no engine work. The sequencer returns to idle, the enable reads 0, and `stop_cause` = 1. Bits 1..3 of such a word are ignored.
- R2: When a valid descriptor completes, the fetched control word is written to the address it was fetched from, with bit 0 cleared and all other bits unchanged.
- R3: Each valid descriptor produces exactly one `eng_start` pulse, one cycle wide. While it is high, `eng_desc_addr` holds the descriptor address and `eng_dst_rd` equals bit 3 of the control word.
- R4: A descriptor with bit 2 = 1 is the last one processed. After its write-back the sequencer idles, the enable reads 0, and `stop_cause` = 2. This takes precedence over bit 1.
- R5: A write-back is issued only after `eng_done`, and it completes before the next fetch is requested.
- R6: After the write-back of a descriptor that is not last, the next fetch address is `ring_base` when bit 1 = 1. Otherwise it is the current address plus `DESC_WORDS*DATA_W/8`, modulo 2^`ADDR_W`.
- R7: Writing the enable to 1 while idle starts a run whose first fetch is at `ring_base`. `stop_cause` reads 0 while that run is active.
- R8: Clearing the enable during a run lets the descriptor in progress finish and be written back. No further fetch is then issued, and `stop_cause` = 3.
- R9: Once a memory request is raised, it stays high with stable address, write flag and write data until `mem_ack`.
- R10: After reset the enable, `busy`, `mem_req` and `eng_start` read 0, and `stop_cause` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | ADDR_W | Byte address of the first ring slot |
| en_wr | input | 1 | Host write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| en_q | output | 1 | Current enable bit |
| busy | output | 1 | Sequencer is not idle |
| stop_cause | output | 2 | 0 active/none, 1 invalid, 2 last flag, 3 host disable |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | DATA_W | Read data |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_desc_addr | output | ADDR_W | Address of the descriptor being processed |
| eng_dst_rd | output | 1 | Destination-read hint from bit 3 |
| eng_done | input | 1 | Engine finished the current descriptor |

## Verification
The bench builds the block with `ADDR_W` = 8, `DATA_W` = 32 and `DESC_WORDS` = 2. This gives an 8-byte stride in a 256-byte space, small enough to hold the whole address space in a bench array. It sweeps all 512 combinations of valid, wrap and last flags over three ring slots, and varies the ring base and engine latency with each pattern. Every walk, implicit or explicit end, and back-to-base wrap is therefore compared with an arithmetic walk of the same image. The 8-bit address also lets a directed case cross the top of the address space and wrap to zero.

// File: rtl/ring_seq_pkg.sv
package ring_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FETCH = 3'd1,
    S_START = 3'd2,
    S_WAIT  = 3'd3,
    S_WB    = 3'd4
  } seq_state_e;

  localparam logic [1:0] CAUSE_NONE    = 2'd0;
  localparam logic [1:0] CAUSE_INVALID = 2'd1;
  localparam logic [1:0] CAUSE_LAST    = 2'd2;
  localparam logic [1:0] CAUSE_HOST    = 2'd3;

  typedef struct packed {
    logic dst_rd;
    logic last;
    logic wrap;
    logic valid;
  } desc_flags_t;

  function automatic desc_flags_t decode_flags(input logic [3:0] low);
    desc_flags_t f;
    f.valid  = low[0];
    f.wrap   = low[1];
    f.last   = low[2];
    f.dst_rd = low[3];
    return f;
  endfunction

endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int ADDR_W = 16,
  parameter int STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              wrap,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] cur
);

  function automatic logic [ADDR_W-1:0] next_slot(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] b,
    input logic              w
  );
    return w ? b : a + ADDR_W'(STRIDE);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= base;
    else if (step) cur <= next_slot(cur, base, wrap);
  end

endmodule

// File: rtl/ring_en_reg.sv
module ring_en_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr,
  input  logic host_val,
  input  logic seq_clr,
  output logic en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en <= 1'b0;
    else if (host_wr) en <= host_val;
    else if (seq_clr) en <= 1'b0;
  end

endmodule

// File: rtl/desc_ring_seq.sv
module desc_ring_seq
  import ring_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int DESC_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              en_wr,
  input  logic              en_wdata,
  output logic              en_q,
  output logic              busy,
  output logic [1:0]        stop_cause,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              eng_start,
  output logic [ADDR_W-1:0] eng_desc_addr,
  output logic              eng_dst_rd,
  input  logic              eng_done
);

  localparam int STRIDE = DESC_WORDS * (DATA_W / 8);

  seq_state_e        st_q, st_d;
  logic [DATA_W-1:0] word_q;
  logic [ADDR_W-1:0] cur_addr;
  desc_flags_t       fetch_fl, held_fl;

  // named internal events
  logic fetch_ack, wb_ack, inv_stop, last_stop, host_stop, launch, go_next;

  assign fetch_fl  = decode_flags(mem_rdata[3:0]);
  assign held_fl   = decode_flags(word_q[3:0]);
  assign fetch_ack = (st_q == S_FETCH) && mem_ack;
  assign wb_ack    = (st_q == S_WB) && mem_ack;
  assign inv_stop  = fetch_ack && !fetch_fl.valid;
  assign last_stop = wb_ack && held_fl.last;
  assign host_stop = wb_ack && !held_fl.last && !en_q;
  assign go_next   = wb_ack && !held_fl.last && en_q;
  assign launch    = (st_q == S_IDLE) && en_q;

  ring_ptr #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (launch),
    .step  (go_next),
    .wrap  (held_fl.wrap),
    .base  (ring_base),
    .cur   (cur_addr)
  );

  ring_en_reg u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_wr  (en_wr),
    .host_val (en_wdata),
    .seq_clr  (inv_stop || last_stop),
    .en       (en_q)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (launch) st_d = S_FETCH;
      S_FETCH: if (fetch_ack) st_d = fetch_fl.valid ? S_START : S_IDLE;
      S_START: st_d = S_WAIT;
      S_WAIT:  if (eng_done) st_d = S_WB;
      S_WB:    if (wb_ack) st_d = go_next ? S_FETCH : S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      word_q     <= '0;
      stop_cause <= CAUSE_NONE;
    end else begin
      st_q <= st_d;
      if (fetch_ack) word_q <= mem_rdata;
      if (launch)         stop_cause <= CAUSE_NONE;
      else if (inv_stop)  stop_cause <= CAUSE_INVALID;
      else if (last_stop) stop_cause <= CAUSE_LAST;
      else if (host_stop) stop_cause <= CAUSE_HOST;
    end
  end

  assign busy          = (st_q != S_IDLE);
  assign mem_req       = (st_q == S_FETCH) || (st_q == S_WB);
  assign mem_we        = (st_q == S_WB);
  assign mem_addr      = cur_addr;
  assign mem_wdata     = {word_q[DATA_W-1:1], 1'b0};
  assign eng_start     = (st_q == S_START);
  assign eng_desc_addr = cur_addr;
  assign eng_dst_rd    = held_fl.dst_rd;

  p_inv_disables_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_stop && !en_wr) |=> (!en_q && !busy && stop_cause == CAUSE_INVALID));

  p_wb_clears_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[0]);

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_last_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_stop && !en_wr) |=> (!en_q && stop_cause == CAUSE_LAST));

  p_wb_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && eng_done) |=> (mem_req && mem_we));

  p_host_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_stop |=> (!mem_req && stop_cause == CAUSE_HOST));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

endmodule

// File: tb/desc_ring_seq_tb_top.sv
`timescale 1ns/1ps
module desc_ring_seq_tb_top;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int DWORDS = 2;
  localparam int STEP = DWORDS * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic          en_wr = 1'b0, en_wdata = 1'b0;
  logic          en_q, busy, mem_req, mem_we, mem_ack, eng_start, eng_dst_rd, eng_done;
  logic [1:0]    stop_cause;
  logic [AW-1:0] mem_addr, eng_desc_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  desc_ring_seq #(.ADDR_W(AW), .DATA_W(DW), .DESC_WORDS(DWORDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .en_wr(en_wr), .en_wdata(en_wdata),
    .en_q(en_q), .busy(busy), .stop_cause(stop_cause), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .eng_start(eng_start), .eng_desc_addr(eng_desc_addr), .eng_dst_rd(eng_dst_rd),
    .eng_done(eng_done));

  // memory image and models
  logic [DW-1:0] img   [64];
  logic [DW-1:0] mem   [64];
  logic          prep = 1'b0;
  int            lat = 0;
  int            ecnt;
  logic          erun;
  logic [AW-1:0] log_addr [16];
  logic          log_dst  [16];
  int            log_n, viol5, viol9;
  logic          pend_wb, prev_pend, prev_we;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_wd;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (prep) begin
      for (int i = 0; i < 64; i++) mem[i] <= img[i];
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:2]];
    end
  end

  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (!rst_n) begin
      erun <= 1'b0; ecnt <= 0;
    end else if (eng_start) begin
      erun <= 1'b1; ecnt <= lat;
    end else if (erun) begin
      if (ecnt == 0) begin eng_done <= 1'b1; erun <= 1'b0; end
      else ecnt <= ecnt - 1;
    end
  end

  always @(posedge clk) begin
    if (prep || !rst_n) begin
      log_n <= 0; viol5 <= 0; viol9 <= 0; pend_wb <= 1'b0; prev_pend <= 1'b0;
    end else begin
      if (eng_start && log_n < 16) begin
        log_addr[log_n] <= eng_desc_addr;
        log_dst[log_n]  <= eng_dst_rd;
        log_n <= log_n + 1;
      end
      if (eng_start) pend_wb <= 1'b1;
      else if (mem_req && mem_we && mem_ack) pend_wb <= 1'b0;
      if ((mem_req && !mem_we && pend_wb) || (mem_req && erun)) viol5 <= viol5 + 1;
      if (prev_pend && !(mem_req && mem_addr == prev_addr && mem_we == prev_we
                         && mem_wdata == prev_wd)) viol9 <= viol9 + 1;
      prev_pend <= mem_req && !mem_ack;
      prev_addr <= mem_addr; prev_we <= mem_we; prev_wd <= mem_wdata;
    end
  end

  // checking
  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected walk computed from the requirements
  logic [DW-1:0] xmem [64];
  logic [AW-1:0] xaddr [16];
  logic          xdst  [16];
  int            xn;
  logic [1:0]    xcause;

  task automatic ref_walk(input logic [AW-1:0] base);
    logic [AW-1:0] a;
    logic [DW-1:0] w;
    for (int i = 0; i < 64; i++) xmem[i] = img[i];
    a = base; xn = 0; xcause = 2'd0;
    for (int k = 0; k < 16; k++) begin
      w = xmem[a[7:2]];
      if (!w[0]) begin xcause = 2'd1; break; end
      xaddr[xn] = a; xdst[xn] = w[3]; xn++;
      xmem[a[7:2]] = w & ~32'd1;
      if (w[2]) begin xcause = 2'd2; break; end
      a = w[1] ? base : a + 8'(STEP);
    end
  endtask

  task automatic load_img;
    @(negedge clk) prep = 1'b1;
    @(negedge clk) prep = 1'b0;
  endtask

  task automatic write_en(input logic v);
    @(negedge clk) begin en_wr = 1'b1; en_wdata = v; end
    @(negedge clk) en_wr = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n;
    n = 0;
    while ((en_q || busy) && n < 2000) begin @(negedge clk); n++; end
    chk(n < 2000, {tag, " run ended"}, n, 0);
  endtask

  task automatic compare(input string tag, input logic [1:0] ecause);
    logic ok_log, ok_mem;
    ok_log = (log_n == xn);
    for (int i = 0; i < 16; i++)
      if (i < xn && i < log_n && (log_addr[i] != xaddr[i] || log_dst[i] != xdst[i])) ok_log = 1'b0;
    chk(ok_log, {tag, " R3 R6 R7 start sequence"}, log_n, xn);
    ok_mem = 1'b1;
    for (int i = 0; i < 64; i++) if (mem[i] !== xmem[i]) ok_mem = 1'b0;
    chk(ok_mem, {tag, " R2 write-back image"}, ok_mem, 1);
    chk(stop_cause == ecause && !en_q, {tag, " R1 R4 cause"}, stop_cause, ecause);
    chk(viol5 == 0 && viol9 == 0, {tag, " R5 R9 ordering"}, viol5 + viol9, 0);
  endtask

  task automatic run_case(input logic [AW-1:0] base, input string tag);
    ref_walk(base);
    load_img();
    ring_base = base;
    write_en(1'b1);
    wait_idle(tag);
    compare(tag, xcause);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) img[i] = 32'h1000_0000 + i * 32'h10;
    repeat (3) @(negedge clk);
    // R10 reset values
    chk(!en_q, "R10 en", en_q, 0);
    chk(!busy, "R10 busy", busy, 0);
    chk(!mem_req, "R10 mem_req", mem_req, 0);
    chk(!eng_start, "R10 eng_start", eng_start, 0);
    chk(stop_cause == 2'd0, "R10 cause", stop_cause, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // sweep: valid/wrap/last over three slots, slot 3 invalid with stray flags (R1)
    for (int p = 0; p < 512; p++) begin
      logic [AW-1:0] b;
      b = 8'((p & 3) * 32);
      for (int i = 0; i < 64; i++) img[i] = 32'h1000_0000 + i * 32'h10;
      for (int s = 0; s < 3; s++) begin
        logic [2:0] f;
        f = 3'((p >> (3 * s)) & 7);
        img[(b + s * STEP) >> 2] = {16'hA5C3, 8'(p), 4'(s), 1'((s + p) & 1), f[2], f[1], f[0]};
      end
      img[(b + 3 * STEP) >> 2] = {16'h5A3C, 8'(p), 8'h0E};
      lat = p % 3;
      run_case(b, "sweep");
    end

    // R6: sequential step past the top of the address space
    for (int i = 0; i < 64; i++) img[i] = 32'h2000_0000 + i;
    img[8'hF0 >> 2] = 32'hCAFE_0009;
    img[8'hF8 >> 2] = 32'hCAFE_0101;
    img[0]          = 32'hCAFE_0205;
    lat = 1;
    run_case(8'hF0, "R6 modulo");

    // R7 and R8: host clears enable mid-run
    for (int i = 0; i < 64; i++) img[i] = 32'h3000_0000 + i;
    for (int s = 0; s < 4; s++) img[(64 + s * STEP) >> 2] = 32'h7700_0001 + (s << 8);
    lat = 4;
    load_img();
    ring_base = 8'd64;
    write_en(1'b1);
    while (log_n == 0) @(negedge clk);
    chk(stop_cause == 2'd0, "R7 cause cleared while active", stop_cause, 0);
    chk(log_addr[0] == 8'd64, "R7 first fetch at base", log_addr[0], 64);
    write_en(1'b0);
    wait_idle("R8");
    chk(log_n == 1, "R8 single descriptor", log_n, 1);
    chk(mem[16] == 32'h7700_0000, "R8 write-back done", mem[16], 32'h7700_0000);
    chk(mem[18] == 32'h7700_0101, "R8 next slot untouched", mem[18], 32'h7700_0101);
    chk(stop_cause == 2'd3, "R8 cause", stop_cause, 3);
    chk(viol5 == 0 && viol9 == 0, "R5 R9 ordering host stop", viol5 + viol9, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule